// File: doc/BRIEF.md
# I2C Bus Error Monitor

This block listens passively to the SCL and SDA wires of an I2C bus and flags protocol misuse. It brings both lines into the system clock domain and recognises START and STOP conditions. It counts the SCL pulses inside every nine-pulse byte frame. It also inspects the first byte after each START to follow 10-bit addressing headers. It does not shift data, arbitrate or generate a clock.

Software reaches the block through a small two-register port. Register 0 holds the interface enable, plus a read-only view of the bus-busy state and of the memory of a 10-bit write header. Register 1 holds the bus-error flag, the error interrupt enable, the master-mode bit, the transfer-interrupt flag and the write-only repeated-start request. When a misuse is seen, the error flag is raised. At the same time the enable is dropped, and every other status and control bit is cleared except the error interrupt enable. The interface cannot be turned back on until software has cleared the flag.

Top module: `i2c_buserr_monitor`

## Requirements
- R1: START (SDA falling while SCL is high) sets the busy bit, register 0 bit 7, and STOP (SDA rising while SCL is high) clears it. Both are judged on the synchronised lines and only while the enable, register 0 bit 0, is 1.
- R2: A START or STOP seen while the frame pulse count is between 2 and 9 inclusive sets the error flag, register 1 bit 7. The count is 0 after START, rises by one on each SCL rising edge, and goes from 9 back to 1. The same condition at a count of 0 or 1 is legal.
- R3: A first byte after START whose upper five bits are 11110 and whose bit 0 is 1 (read) sets the error flag on its ninth SCL pulse, unless a 10-bit write header (bit 0 is 0) was seen earlier. That memory shows in register 0 bit 6 and is cleared by STOP.
- R4: When the error flag is raised, the enable, the master bit (register 1 bit 4), the transfer flag (register 1 bit 3) and the busy and 10-bit memory bits all go to 0. The error interrupt enable (register 1 bit 6) keeps its value.
- R5: The error flag is set only by the detector. Writing 0 to register 1 bit 7 clears it, and writing 1 leaves it unchanged.
- R6: A read with the read-modify-write qualifier high returns register 1 bit 7 as 1, whatever the flag holds.
- R7: Writing 1 to the enable while the error flag is 1 leaves the enable at 0.
- R8: The interrupt output is 1 exactly while the error flag and the error interrupt enable are both 1.
- R9: Register 1 bit 5 always reads 0. Writing it as 1 while the master bit and the transfer flag are both 1 gives a single-cycle repeated-start pulse and clears the transfer flag. Otherwise the write gives no pulse.
- R10: Reset clears every register bit, so both registers read 0 and all outputs are low.
- R11: While the enable is 0, bus activity never raises the error flag.
- R12: A pulse on the transfer-event input sets the transfer flag while the enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| xfer_event_i | input | 1 | Pulse that raises the transfer-interrupt flag |
| reg_sel_i | input | 1 | Register select: 0 for control/status, 1 for bus-error control |
| reg_we_i | input | 1 | Write strobe |
| reg_rmw_i | input | 1 | Read-modify-write qualifier on reads |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for the selected register |
| irq_o | output | 1 | Bus-error interrupt request |
| enable_o | output | 1 | Interface enable |
| rstart_o | output | 1 | Single-cycle repeated-start request |

## Verification
A frame counter that is off by one either misses the error for a condition at pulse 2 or at pulse 9, or raises a false one at pulse 1. Either way register 1 reads wrong a few cycles after the bus event, once the sync and edge stages have been crossed. A stale 10-bit write memory shows at once in register 0 bit 6 after a STOP, and in a missing or extra error on the next read header. A wrong error clear path shows on the very next register read, or as an enable output that comes back while the flag is still set.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

   // bus-error control register (select = 1)
   localparam int BC_ERR = 7;
   localparam int BC_IE  = 6;
   localparam int BC_RS  = 5;
   localparam int BC_MST = 4;
   localparam int BC_XF  = 3;

   // control/status register (select = 0)
   localparam int ST_BUSY = 7;
   localparam int ST_TEN  = 6;
   localparam int ST_EN   = 0;

   // minimum register width that holds the fields above
   localparam int MIN_DATA_W = 8;

   // one-cycle bus observations after synchronisation
   typedef struct packed {
      logic start;
      logic stop;
      logic scl_rise;
      logic sda;
   } bus_ev_t;

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   initial assert (STAGES >= 2) else $fatal(1, "i2cmon_sync: STAGES must be at least 2");

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/i2cmon_cond.sv
module i2cmon_cond
   import i2cmon_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_i,
   input  logic    sda_i,
   output bus_ev_t ev
);

   localparam int NLINES = 2;

   logic [NLINES-1:0] raw;
   logic [NLINES-1:0] cur;
   logic [NLINES-1:0] prev;

   assign raw = {scl_i, sda_i};

   for (genvar i = 0; i < NLINES; i++) begin : g_line
      i2cmon_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (raw[i]),
         .dout (cur[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '1;
      else        prev <= cur;
   end

   logic scl_c, sda_c, scl_p, sda_p;
   assign scl_c = cur[1];
   assign sda_c = cur[0];
   assign scl_p = prev[1];
   assign sda_p = prev[0];

   always_comb begin
      ev.start    = scl_c && scl_p && sda_p && !sda_c;
      ev.stop     = scl_c && scl_p && !sda_p && sda_c;
      ev.scl_rise = scl_c && !scl_p;
      ev.sda      = sda_c;
   end

endmodule

// File: rtl/i2cmon_frame.sv
module i2cmon_frame
   import i2cmon_pkg::*;
#(
   parameter int         FRAME_BITS = 9,
   parameter int         WIN_LO     = 2,
   parameter logic [4:0] TEN_PREFIX = 5'b11110
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    run,
   input  bus_ev_t ev,
   output logic    err_det,
   output logic    busy_o,
   output logic    tenw_o
);

   localparam int ADDR_W = FRAME_BITS - 1;
   localparam int PFX_W  = 5;
   localparam int CNT_W  = $clog2(FRAME_BITS + 1);
   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS);
   localparam logic [CNT_W-1:0] ADDR_POS = CNT_W'(ADDR_W);
   localparam logic [CNT_W-1:0] WIN_POS  = CNT_W'(WIN_LO);
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   initial assert (ADDR_W >= PFX_W + 1) else $fatal(1, "i2cmon_frame: frame too short for a 10-bit header");
   initial assert (WIN_LO >= 1 && WIN_LO <= FRAME_BITS) else $fatal(1, "i2cmon_frame: bad window start");

   logic             busy;
   logic             first;
   logic             tenw;
   logic [CNT_W-1:0] cnt;
   logic [ADDR_W-1:0] shreg;

   logic at_hdr_end;
   logic is_hdr;
   logic misplaced;
   logic bad_read;

   assign at_hdr_end = busy && first && ev.scl_rise && (cnt == ADDR_POS);
   assign is_hdr     = (shreg[ADDR_W-1 -: PFX_W] == TEN_PREFIX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         first <= 1'b0;
         tenw  <= 1'b0;
         cnt   <= '0;
         shreg <= '0;
      end else if (!run) begin
         busy  <= 1'b0;
         first <= 1'b0;
         tenw  <= 1'b0;
         cnt   <= '0;
         shreg <= '0;
      end else if (ev.start) begin
         busy  <= 1'b1;
         first <= 1'b1;
         cnt   <= '0;
         shreg <= '0;
      end else if (ev.stop) begin
         busy  <= 1'b0;
         first <= 1'b0;
         tenw  <= 1'b0;
         cnt   <= '0;
      end else if (busy && ev.scl_rise) begin
         if (cnt == LAST_POS) cnt <= ONE;
         else                 cnt <= cnt + ONE;
         if (first && (cnt < ADDR_POS))
            shreg <= {shreg[ADDR_W-2:0], ev.sda};
         if (at_hdr_end) begin
            first <= 1'b0;
            if (is_hdr && !shreg[0]) tenw <= 1'b1;
         end
      end
   end

   assign misplaced = busy && (ev.start || ev.stop) && (cnt >= WIN_POS) && (cnt <= LAST_POS);
   assign bad_read  = at_hdr_end && is_hdr && shreg[0] && !tenw;
   assign err_det   = run && (misplaced || bad_read);
   assign busy_o    = busy;
   assign tenw_o    = tenw;

endmodule

// File: rtl/i2cmon_regs.sv
module i2cmon_regs
   import i2cmon_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              we,
   input  logic              rmw,
   input  logic [DATA_W-1:0] wdata,
   input  logic              err_det,
   input  logic              xfer_event,
   input  logic              busy,
   input  logic              tenw,
   output logic [DATA_W-1:0] rdata,
   output logic              enable,
   output logic              err_flag,
   output logic              xfer_flag,
   output logic              rstart,
   output logic              irq
);

   initial assert (DATA_W >= MIN_DATA_W) else $fatal(1, "i2cmon_regs: DATA_W too small");

   logic err_ie;
   logic master;
   logic wr_bc;
   logic wr_st;
   logic rs_ok;

   assign wr_bc = we && sel;
   assign wr_st = we && !sel;
   assign rs_ok = wr_bc && wdata[BC_RS] && master && xfer_flag && !err_det;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable    <= 1'b0;
         err_flag  <= 1'b0;
         err_ie    <= 1'b0;
         master    <= 1'b0;
         xfer_flag <= 1'b0;
         rstart    <= 1'b0;
      end else begin
         rstart <= rs_ok;
         if (wr_bc) err_ie <= wdata[BC_IE];
         if (err_det) begin
            err_flag  <= 1'b1;
            enable    <= 1'b0;
            master    <= 1'b0;
            xfer_flag <= 1'b0;
         end else begin
            if (wr_st) enable <= wdata[ST_EN] && !err_flag;
            if (wr_bc) begin
               master <= wdata[BC_MST];
               if (!wdata[BC_ERR]) err_flag <= 1'b0;
            end
            if (rs_ok)                        xfer_flag <= 1'b0;
            else if (xfer_event && enable)    xfer_flag <= 1'b1;
            else if (wr_bc && !wdata[BC_XF])  xfer_flag <= 1'b0;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (sel) begin
         rdata[BC_ERR] = err_flag || rmw;
         rdata[BC_IE]  = err_ie;
         rdata[BC_MST] = master;
         rdata[BC_XF]  = xfer_flag;
      end else begin
         rdata[ST_BUSY] = busy;
         rdata[ST_TEN]  = tenw;
         rdata[ST_EN]   = enable;
      end
   end

   assign irq = err_flag && err_ie;

endmodule

// File: rtl/i2c_buserr_monitor.sv
module i2c_buserr_monitor
   import i2cmon_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int FRAME_BITS  = 9,
   parameter int WIN_LO      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              xfer_event_i,
   input  logic              reg_sel_i,
   input  logic              reg_we_i,
   input  logic              reg_rmw_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irq_o,
   output logic              enable_o,
   output logic              rstart_o
);

   bus_ev_t ev;
   logic    err_det;
   logic    err_flag;
   logic    xfer_flag;
   logic    busy;
   logic    tenw;

   i2cmon_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk  (clk),
      .rst_n(rst_n),
      .scl_i(scl_i),
      .sda_i(sda_i),
      .ev   (ev)
   );

   i2cmon_frame #(.FRAME_BITS(FRAME_BITS), .WIN_LO(WIN_LO)) u_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (enable_o),
      .ev     (ev),
      .err_det(err_det),
      .busy_o (busy),
      .tenw_o (tenw)
   );

   i2cmon_regs #(.DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (reg_sel_i),
      .we        (reg_we_i),
      .rmw       (reg_rmw_i),
      .wdata     (reg_wdata_i),
      .err_det   (err_det),
      .xfer_event(xfer_event_i),
      .busy      (busy),
      .tenw      (tenw),
      .rdata     (reg_rdata_o),
      .enable    (enable_o),
      .err_flag  (err_flag),
      .xfer_flag (xfer_flag),
      .rstart    (rstart_o),
      .irq       (irq_o)
   );

endmodule

// File: rtl/i2cmon_checker.sv
module i2cmon_checker (
   input logic clk,
   input logic rst_n,
   input logic err_flag,
   input logic err_det,
   input logic enable_o,
   input logic irq_o,
   input logic rstart_o,
   input logic xfer_flag
);

   a_r4_enable_drops: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> !enable_o);

   a_r5_flag_from_detector: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> $past(err_det));

   a_r7_no_reenable: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> !$rose(enable_o));

   a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> err_flag);

   a_r9_rstart_single: assert property (@(posedge clk) disable iff (!rst_n)
      rstart_o |=> !rstart_o);

   a_r9_rstart_clears_xfer: assert property (@(posedge clk) disable iff (!rst_n)
      rstart_o |-> !xfer_flag);

endmodule

bind i2c_buserr_monitor i2cmon_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .err_flag (err_flag),
   .err_det  (err_det),
   .enable_o (enable_o),
   .irq_o    (irq_o),
   .rstart_o (rstart_o),
   .xfer_flag(xfer_flag)
);

// File: tb/i2c_buserr_monitor_test.sv
`timescale 1ns/1ps
module i2c_buserr_monitor_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda = 1'b1;
   logic       xev = 1'b0;
   logic       sel = 1'b0;
   logic       we = 1'b0;
   logic       rmw = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq, en, rs;

   int n_chk = 0;
   int n_fail = 0;
   int rs_pulses = 0;

   always #10 clk = ~clk;

   i2c_buserr_monitor uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl),
      .sda_i       (sda),
      .xfer_event_i(xev),
      .reg_sel_i   (sel),
      .reg_we_i    (we),
      .reg_rmw_i   (rmw),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata),
      .irq_o       (irq),
      .enable_o    (en),
      .rstart_o    (rs)
   );

   always @(negedge clk) if (rs) rs_pulses++;

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic hold();
      repeat (5) @(negedge clk);
   endtask

   task automatic rd(input logic s, input logic m, output logic [7:0] d);
      @(negedge clk);
      sel = s; rmw = m;
      #2 d = rdata;
      rmw = 1'b0;
   endtask

   task automatic wr(input logic s, input logic [7:0] v);
      @(negedge clk);
      sel = s; wdata = v; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic pulse_xfer();
      @(negedge clk); xev = 1'b1;
      @(negedge clk); xev = 1'b0;
   endtask

   task automatic bus_start();
      sda = 1'b1; scl = 1'b1; hold();
      sda = 1'b0; hold();
      scl = 1'b0; hold();
   endtask

   task automatic bus_rep_start();
      sda = 1'b1; hold();
      scl = 1'b1; hold();
      sda = 1'b0; hold();
      scl = 1'b0; hold();
   endtask

   task automatic bus_stop();
      sda = 1'b0; hold();
      scl = 1'b1; hold();
      sda = 1'b1; hold();
   endtask

   task automatic bus_bit(input logic b);
      sda = b; hold();
      scl = 1'b1; hold();
      scl = 1'b0; hold();
   endtask

   task automatic bus_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) bus_bit(v[i]);
      bus_bit(1'b0);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(1'b0, 1'b0, d); chk("R10 status after reset", d, 8'h00);
      rd(1'b1, 1'b0, d); chk("R10 bus control after reset", d, 8'h00);
      chk("R10 outputs after reset", {5'b0, irq, en, rs}, 8'h00);
   endtask

   task automatic t_disabled();
      logic [7:0] d;
      bus_start(); bus_bit(1'b1); bus_rep_start(); bus_stop();
      rd(1'b1, 1'b0, d); chk("R11 no error while disabled", d, 8'h00);
   endtask

   task automatic t_busy();
      logic [7:0] d;
      wr(1'b0, 8'h01);
      bus_start();
      rd(1'b0, 1'b0, d); chk("R1 busy after START", d, 8'h81);
      bus_stop();
      rd(1'b0, 1'b0, d); chk("R1 idle after STOP", d, 8'h01);
   endtask

   task automatic t_legal_positions();
      logic [7:0] d;
      sda = 1'b1; scl = 1'b1; hold();
      sda = 1'b0; hold();
      sda = 1'b1; hold();          // STOP at count 0
      bus_start();
      bus_rep_start();             // START at count 1
      bus_byte(8'h50);
      bus_rep_start();             // wrap to 1, START
      bus_stop();                  // STOP at count 1
      rd(1'b1, 1'b0, d); chk("R2 conditions at count 0/1 legal", d, 8'h00);
   endtask

   task automatic t_err_start_pos2();
      logic [7:0] d;
      wr(1'b1, 8'h50);
      pulse_xfer();
      rd(1'b1, 1'b0, d); chk("R12 transfer flag set by event", d, 8'h58);
      chk("R8 no irq before error", {7'b0, irq}, 8'h00);
      bus_start(); bus_bit(1'b1);
      bus_rep_start();             // START at count 2
      rd(1'b1, 1'b0, d); chk("R2 START at count 2 errors; R4 bits cleared", d, 8'hC0);
      rd(1'b0, 1'b0, d); chk("R4 enable and busy cleared", d, 8'h00);
      chk("R8 irq with flag and enable", {6'b0, irq, en}, 8'h02);
      bus_stop();
   endtask

   task automatic t_clear();
      logic [7:0] d;
      wr(1'b0, 8'h01);
      rd(1'b0, 1'b0, d); chk("R7 enable write ignored while flagged", d, 8'h00);
      wr(1'b1, 8'hC0);
      rd(1'b1, 1'b0, d); chk("R5 writing 1 keeps flag", d, 8'hC0);
      wr(1'b1, 8'h40);
      rd(1'b1, 1'b0, d); chk("R5 writing 0 clears flag", d, 8'h40);
      chk("R8 irq low once flag cleared", {7'b0, irq}, 8'h00);
      rd(1'b1, 1'b1, d); chk("R6 rmw read shows flag as 1", d, 8'hC0);
      wr(1'b0, 8'h01);
      rd(1'b0, 1'b0, d); chk("R7 enable accepted after clear", d, 8'h01);
   endtask

   task automatic t_err_stop_pos9();
      logic [7:0] d;
      wr(1'b1, 8'h00);
      bus_start();
      for (int i = 0; i < 8; i++) bus_bit(1'b1);
      sda = 1'b0; hold();
      scl = 1'b1; hold();          // count 9
      sda = 1'b1; hold();          // STOP at count 9
      rd(1'b1, 1'b0, d); chk("R2 STOP at count 9 errors", d, 8'h80);
      chk("R8 no irq with enable off", {7'b0, irq}, 8'h00);
      wr(1'b1, 8'h00);
      wr(1'b0, 8'h01);
   endtask

   task automatic t_tenbit();
      logic [7:0] d;
      bus_start(); bus_byte(8'hF0);
      rd(1'b0, 1'b0, d); chk("R3 write header remembered", d, 8'hC1);
      bus_rep_start(); bus_byte(8'hF1);
      rd(1'b1, 1'b0, d); chk("R3 read header after write legal", d, 8'h00);
      bus_stop();
      rd(1'b0, 1'b0, d); chk("R3 STOP clears header memory", d, 8'h01);
      bus_start(); bus_byte(8'hA1); bus_stop();
      rd(1'b1, 1'b0, d); chk("R3 plain read address legal", d, 8'h00);
      bus_start(); bus_byte(8'hF1);
      rd(1'b1, 1'b0, d); chk("R3 read header first errors", d, 8'h80);
      bus_stop();
      wr(1'b1, 8'h00);
      wr(1'b0, 8'h01);
   endtask

   task automatic t_rstart();
      logic [7:0] d;
      int base;
      base = rs_pulses;
      wr(1'b1, 8'h10);
      wr(1'b1, 8'h30);             // master but no transfer flag
      rd(1'b1, 1'b0, d); chk("R9 no effect without transfer flag", d, 8'h10);
      chk("R9 no pulse without transfer flag", 8'(rs_pulses - base), 8'h00);
      pulse_xfer();
      wr(1'b1, 8'h38);
      rd(1'b1, 1'b0, d); chk("R9 transfer flag cleared, bit reads 0", d, 8'h10);
      chk("R9 one pulse", 8'(rs_pulses - base), 8'h01);
      wr(1'b1, 8'h00);
      pulse_xfer();
      wr(1'b1, 8'h28);             // not master
      rd(1'b1, 1'b0, d); chk("R9 no effect outside master mode", d, 8'h08);
      chk("R9 still one pulse", 8'(rs_pulses - base), 8'h01);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_disabled();
      t_busy();
      t_legal_positions();
      t_err_start_pos2();
      t_clear();
      t_err_stop_pos9();
      t_tenbit();
      t_rstart();
      finish_run();
   end

endmodule